// File: doc/BRIEF.md
# Periodic Down-Count Timer

A single-channel timer peripheral reached through a plain 32-bit register port with byte addresses and separate read and write strobes. Software picks a prescale code, a reload count and a mode, then sets the enable bit. The counter is 16 bits wide and counts down once per prescaled tick. When it expires, a sticky interrupt flag sets and drives the interrupt line as a level. Software clears the flag by writing one to it.

The sequencing core is a two-state machine. ST_IDLE is the stopped state. On START (enable seen at 1) the machine loads the counter from the reload register and moves to ST_RUN. ST_RUN decrements the counter on each tick. On RELOAD (periodic expiry) it stays in ST_RUN and reloads. On FINISH (one-shot expiry) it returns to ST_IDLE and clears the enable bit itself. On STOP (enable seen at 0) it returns to ST_IDLE without expiring.

Top module: `ptimer_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The register offsets are status 0x00 (bit 0 = flag), reload 0x10 (bits 15:0), and control 0x18 (bit 7 = enable, bit 4 = periodic, bits 3:0 = prescale code). All other bits read zero. Every control field can be written and read back while enable is 0. A read-modify-write that changes only bit 7 leaves the other fields unchanged.
- R3: Prescale code v makes one counter tick every 2^(v+1) clocks. For example, code 0xE gives one tick per 32768 clocks.
- R4: Suppose a write sets enable at clock edge E. The counter loads at edge E+1. The flag sets at edge E+1+N*2^(v+1), where N is max(reload,1).
- R5: Writing 1 to status bit 0 clears the flag. Writing 0 to that bit has no effect.
- R6: An expiry sets the flag, and the flag stays set until it is cleared. If an expiry and a clear write fall on the same edge, the expiry wins.
- R7: In periodic mode (bit 4 = 1), the counter reloads from the reload register at every expiry and keeps running. A reload write made while the counter runs takes effect only at the next load.
- R8: In one-shot mode (bit 4 = 0), the counter stops at expiry and the hardware clears the enable bit. If a control write falls on the expiry edge, the hardware clear of the enable bit takes priority, and the other fields take the written values.
- R9: Clearing enable stops the count, so no expiry follows. Enabling again restarts the count from the full reload value.
- R10: Reads at offsets not listed in R2 return zero. Writes to those offsets change no register.
- R11: `irq_o` equals the status flag in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, taken on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while bus_rd is high, zero otherwise |
| irq_o | output | 1 | Interrupt level |

## Verification
Two pairs of functions can land on the same edge. The first pair is a counter expiry and a software write-one-to-clear of the flag. The second pair is a one-shot expiry and a software write to the control register. The bench works out the expiry edge from R4 and issues the write so that it lands on exactly that edge. It then expects the flag to stay set, or the enable bit to read back zero while the other written fields are kept. A behavioural model checks the interrupt level on every clock throughout the run.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
    localparam int CODE_W = 4;
    localparam int EN_BIT = 7;
    localparam int PER_BIT = 4;
    localparam logic [7:0] OFS_STAT = 8'h00;
    localparam logic [7:0] OFS_LOAD = 8'h10;
    localparam logic [7:0] OFS_CTRL = 8'h18;

    typedef enum logic {ST_IDLE, ST_RUN} tmr_state_e;

    typedef struct packed {
        logic              en;
        logic              per;
        logic [CODE_W-1:0] code;
    } ctrl_t;
endpackage

// File: rtl/ptimer_regs.sv
module ptimer_regs
    import ptimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              expire_i,
    input  logic              hw_dis_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  load_o,
    output logic              flag_o
);
    logic              sel_stat, sel_load, sel_ctrl;
    logic              w1c;
    ctrl_t             ctrl_q, ctrl_d;
    logic [CNT_W-1:0]  load_q;
    logic              flag_q;

    assign sel_stat = (addr_i == ADDR_W'(OFS_STAT));
    assign sel_load = (addr_i == ADDR_W'(OFS_LOAD));
    assign sel_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
    assign w1c      = wr_i && sel_stat && wdata_i[0];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i && sel_ctrl) begin
            ctrl_d.en   = wdata_i[EN_BIT];
            ctrl_d.per  = wdata_i[PER_BIT];
            ctrl_d.code = wdata_i[CODE_W-1:0];
        end
        if (hw_dis_i) ctrl_d.en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            flag_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_i && sel_load) load_q <= wdata_i[CNT_W-1:0];
            flag_q <= expire_i | (flag_q & ~w1c);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (sel_stat) rdata_o[0] = flag_q;
            if (sel_load) rdata_o[CNT_W-1:0] = load_q;
            if (sel_ctrl) begin
                rdata_o[EN_BIT]       = ctrl_q.en;
                rdata_o[PER_BIT]      = ctrl_q.per;
                rdata_o[CODE_W-1:0]   = ctrl_q.code;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign load_o = load_q;
    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_q); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !expire_i) |=> !flag_q); // R5
    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sel_stat && !sel_load && !sel_ctrl && !hw_dis_i && !expire_i)
        |=> ($stable(load_q) && $stable(ctrl_q) && $stable(flag_q))); // R10
endmodule

// File: rtl/ptimer_prescale.sv
module ptimer_prescale
    import ptimer_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] code_i,
    output logic          tick_o
);
    localparam int PRE_W = 1 << CW;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] last;

    assign span   = (PRE_W+1)'(2) << code_i;
    assign last   = PRE_W'(span - (PRE_W+1)'(1));
    assign tick_o = run_i && (pre_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) pre_q <= '0;
        else if (tick_o)      pre_q <= '0;
        else                  pre_q <= pre_q + PRE_W'(1);
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_i != $past(code_i)) |-> (pre_q <= last || !run_i || $past(pre_q) > last)); // R3
    AST_PRE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> (pre_q == '0)); // R4
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
    import ptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             per_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic             expire_o,
    output logic             hw_dis_o
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) begin
                    state_d = ST_RUN;
                    cnt_d   = load_i;
                end
            end
            ST_RUN: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else if (wrap) begin
                    if (per_i) begin
                        cnt_d = load_i;
                    end else begin
                        cnt_d   = '0;
                        state_d = ST_IDLE;
                    end
                end else if (tick_i) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o    = (state_q == ST_RUN);
        wrap     = run_o && en_i && tick_i && (cnt_q <= CNT_W'(1));
        expire_o = wrap;
        hw_dis_o = wrap && !per_i;
    end

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        hw_dis_o |=> (state_q == ST_IDLE)); // R8
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && en_i && tick_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && en_i && !tick_i) |=> $stable(cnt_q)); // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !en_i) |=> (state_q == ST_IDLE)); // R9
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic             flag, run, tick, expire, hw_dis;

    ptimer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .rd_i(bus_rd), .rdata_o(bus_rdata),
        .expire_i(expire), .hw_dis_i(hw_dis), .ctrl_o(ctrl),
        .load_o(load_val), .flag_o(flag)
    );

    ptimer_prescale #(.CW(CODE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .code_i(ctrl.code), .tick_o(tick)
    );

    ptimer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en_i(ctrl.en), .per_i(ctrl.per),
        .load_i(load_val), .tick_i(tick), .run_o(run),
        .expire_o(expire), .hw_dis_o(hw_dis)
    );

    assign irq_o = flag;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(expire)); // R11
endmodule

// File: tb/ptimer_tb_top.sv
module ptimer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit percyc = 1'b0;

    always #4 clk = ~clk;

    ptimer_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // behavioural reference
    int m_en, m_per, m_code, m_load, m_flag, m_run, m_cnt, m_pre;

    always @(posedge clk) begin
        int exp_now, hw_off;
        exp_now = 0;
        hw_off = 0;
        if (!rst_n) begin
            m_en = 0; m_per = 0; m_code = 0; m_load = 0;
            m_flag = 0; m_run = 0; m_cnt = 0; m_pre = 0;
        end else begin
            if (m_run != 0) begin
                if (m_en == 0) begin
                    m_run = 0;
                    m_pre = 0;
                end else if (m_pre == (2 << m_code) - 1) begin
                    m_pre = 0;
                    if (m_cnt <= 1) begin
                        exp_now = 1;
                        if (m_per != 0) m_cnt = m_load;
                        else begin m_cnt = 0; m_run = 0; hw_off = 1; end
                    end else m_cnt = m_cnt - 1;
                end else m_pre = m_pre + 1;
            end else if (m_en != 0) begin
                m_run = 1;
                m_cnt = m_load;
                m_pre = 0;
            end
            if (bus_wr && bus_addr == 8'h00 && bus_wdata[0]) m_flag = 0;
            if (bus_wr && bus_addr == 8'h10) m_load = int'(bus_wdata[15:0]);
            if (bus_wr && bus_addr == 8'h18) begin
                m_en = bus_wdata[7]; m_per = bus_wdata[4]; m_code = int'(bus_wdata[3:0]);
            end
            if (hw_off != 0) m_en = 0;
            if (exp_now != 0) m_flag = 1;
        end
        cyc++;
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 8'h00) v[0] = (m_flag != 0);
        if (a == 8'h10) v[15:0] = 16'(m_load);
        if (a == 8'h18) begin
            v[7] = (m_en != 0); v[4] = (m_per != 0); v[3:0] = 4'(m_code);
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (percyc) check(irq_o == (m_flag != 0), "R11 irq vs model", irq_o, m_flag);
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] d, e;
        rd(a, d);
        e = m_read(a);
        check(d == e, tag, d, e);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cnt_to_irq(output int n);
        n = 0;
        while (!irq_o && n < 70000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        check(1'b0, "watchdog", cyc, 150000);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int n;
        wait_n(3);
        rst_n = 1'b1;
        percyc = 1'b1;

        // R1 reset state
        rd(8'h00, d); check(d == 0, "R1 status", d, 0);
        rd(8'h10, d); check(d == 0, "R1 reload", d, 0);
        rd(8'h18, d); check(d == 0, "R1 control", d, 0);
        check(irq_o == 1'b0, "R1 irq", irq_o, 0);

        // R2 field programming while disabled, RMW of enable
        wr(8'h18, 32'hFFFF_FF6E);
        rd(8'h18, d); check(d == 32'h0000_000E, "R2 control fields", d, 32'hE);
        wr(8'h10, 32'hABCD_0005);
        rd(8'h10, d); check(d == 32'h0000_0005, "R2 reload field", d, 5);
        wr(8'h18, 32'h0000_0002);
        rd(8'h18, d);
        wr(8'h18, d | 32'h80);
        rd(8'h18, d); check(d == 32'h0000_0082, "R2 RMW enable", d, 32'h82);

        // R4/R3 one-shot with code 2, reload 5: 1 + 5*8 cycles
        cnt_to_irq(n);
        check(n == 41, "R4 R3 expiry latency", n, 41);
        rd(8'h18, d); check(d == 32'h0000_0002, "R8 enable cleared", d, 2);
        wait_n(100);
        rd_chk(8'h00, "R8 stopped flag");

        // R5 write 0 ignored, write 1 clears
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, d); check(d == 1, "R5 write zero", d, 1);
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, d); check(d == 0, "R5 w1c", d, 0);
        wait_n(60);
        check(irq_o == 1'b0, "R8 no restart", irq_o, 0);

        // R3 code 0, reload 0 treated as 1: 1 + 2 cycles
        wr(8'h10, 32'h0);
        wr(8'h18, 32'h80);
        cnt_to_irq(n);
        check(n == 3, "R3 R4 reload zero", n, 3);
        wr(8'h00, 32'h1);

        // R6 periodic, code 0, reload 2: period 4, set vs clear collision
        wr(8'h10, 32'h2);
        wr(8'h18, 32'h90);               // edge E
        cnt_to_irq(n);                   // expiry at E+5
        check(n == 5, "R7 first period", n, 5);
        wr(8'h00, 32'h1);                // edge E+6
        check(irq_o == 1'b0, "R5 cleared before collision", irq_o, 0);
        wait_n(2);
        wr(8'h00, 32'h1);                // edge E+9 = expiry
        check(irq_o == 1'b1, "R6 expiry beats clear", irq_o, 1);
        rd(8'h18, d); check(d[7] == 1'b1, "R7 still enabled", d, 32'h90);

        // R7 reload change while running takes effect on next load
        wr(8'h10, 32'h6);
        wait_n(40);
        rd_chk(8'h00, "R7 periodic flag");
        rd_chk(8'h10, "R7 reload readback");
        wr(8'h18, 32'h10);
        wr(8'h00, 32'h1);

        // R9 disable stops, re-enable restarts full count (code 3, reload 10)
        wr(8'h10, 32'd10);
        wr(8'h18, 32'h93);
        wait_n(50);
        rd(8'h18, d);
        wr(8'h18, d & ~32'h80);
        wait_n(300);
        check(irq_o == 1'b0, "R9 no expiry while stopped", irq_o, 0);
        rd(8'h18, d);
        wr(8'h18, d | 32'h80);
        cnt_to_irq(n);
        check(n == 161, "R9 full restart", n, 161);
        wr(8'h18, 32'h0);
        wr(8'h00, 32'h1);

        // R8 one-shot expiry collides with control write, code 0 reload 2
        wr(8'h10, 32'h2);
        wr(8'h18, 32'h80);               // edge E, expiry E+5
        wait_n(4);
        wr(8'h18, 32'h81);               // edge E+5
        rd(8'h18, d); check(d == 32'h1, "R8 hw clear wins", d, 1);
        rd_chk(8'h18, "R8 control vs model");
        wr(8'h00, 32'h1);

        // R10 unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h04, d); check(d == 0, "R10 read 0x04", d, 0);
        rd(8'h1C, d); check(d == 0, "R10 read 0x1C", d, 0);
        rd(8'h10, d); check(d == 2, "R10 reload intact", d, 2);
        rd(8'h18, d); check(d == 1, "R10 control intact", d, 1);
        rd(8'h00, d); check(d == 0, "R10 status intact", d, 0);

        wait_n(5);
        percyc = 1'b0;
        finish_run();
    end
endmodule